// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Initialization Sequencer

This block brings a multiplexed-address DRAM module out of power-up and then keeps its contents alive. After reset it stays silent for a programmable settling time. It then runs a burst of CAS-before-RAS cycles, which use the memory's internal row counter, and only after that burst does it declare the memory usable. From then on a free-running interval counter schedules one CAS-before-RAS cycle per interval. The default interval spreads 2048 rows over a 32 ms retention window.

The sequencer does not own the strobe pins permanently. When work is due it raises a bus request towards the access controller. It waits for a grant, and then drives RAS, CAS and WE itself, with a drive-enable output telling the pin multiplexer to select it. Intervals that expire while the grant is withheld are counted up to a configurable limit. They are then serviced back to back in one bus tenure. Host accesses are turned away until initialization is complete. All timing is given as parameters in clock cycles, and an asynchronous reset is released through a two-stage synchronizer.

Top module: `dram_rfsh_seq`

## Requirements
- R1: While rst_n is low: ras_n, cas_n and we_n are 1; bus_req, drv_en, mem_ready and host_ok are 0.
- R2: bus_req first rises exactly INIT_WAIT_CYC+3 rising clock edges after rst_n is released (two synchronizer edges, then a wait of INIT_WAIT_CYC cycles). Before that, no strobe toggles.
- R3: After the wait, exactly INIT_CBR_CNT refresh cycles run before mem_ready rises. mem_ready rises one cycle after the precharge of the last of these cycles and never falls again until reset.
- R4: In every refresh cycle cas_n falls first and stays low for exactly T_CSR cycles with ras_n high. cas_n then stays low for the whole time ras_n is low.
- R5: ras_n stays low for exactly T_RAS cycles. Both strobes then stay high for T_RP cycles before the next cycle or the release of the bus.
- R6: we_n is 1 at all times, so that every cycle is taken as a refresh.
- R7: bus_req, once raised, stays high until a grant is seen. bus_gnt has no effect while bus_req is low: both strobes stay high and no cycle starts.
- R8: Once mem_ready is high, one refresh falls due every RFSH_INTERVAL cycles. With an immediate grant, successive ras_n falling edges are exactly RFSH_INTERVAL cycles apart.
- R9: Due refreshes that have not yet been serviced are counted up to MAX_PENDING; further expiries are dropped. All counted refreshes run back to back, T_CSR+T_RAS+T_RP cycles apart, within one grant.
- R10: host_ok equals host_req while mem_ready is high and is 0 otherwise.
- R11: drv_en is high from the cycle cas_n first falls until the end of the last precharge of a tenure, and bus_req is high whenever drv_en is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_gnt | input | 1 | Grant of the DRAM pins from the access controller |
| host_req | input | 1 | Host access request |
| bus_req | output | 1 | Request for the DRAM pins |
| drv_en | output | 1 | Sequencer strobes own the pins |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low (held high) |
| mem_ready | output | 1 | Initialization complete |
| host_ok | output | 1 | Host request accepted |

## Verification
The bench builds the block with a 40-cycle settling wait, 8 initialization cycles, a 30-cycle refresh interval, a pending limit of 3, and strobe timings of 2, 3 and 2 cycles. These small values let the settling wait, the whole initialization burst, several steady intervals and a withheld grant long enough to saturate the pending count all fit into a few hundred cycles. The non-unit CAS setup and precharge counts make off-by-one errors in each phase visible. The grant latency is varied and a grant is presented while nothing is requested.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_CSU,
    ST_RAS,
    ST_PRE
  } cbr_st_e;

  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/rfsh_init_ctl.sv
module rfsh_init_ctl
  import dram_rfsh_pkg::*;
#(
  parameter int unsigned INIT_WAIT_CYC = 20000,
  parameter int unsigned INIT_CBR_CNT  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_start,
  input  logic cyc_done,
  output logic wait_done,
  output logic init_left_nz,
  output logic ready
);

  localparam int unsigned WW = cnt_w(INIT_WAIT_CYC);
  localparam int unsigned CW = cnt_w(INIT_CBR_CNT + 1);

  logic [WW-1:0] wait_cnt_q, wait_cnt_d;
  logic          wait_done_q, wait_done_d;
  logic [CW-1:0] left_q, left_d;
  logic          ready_q, ready_d;
  logic          wait_en;

  assign wait_en = !wait_done_q;

  always_comb begin
    wait_cnt_d  = wait_cnt_q;
    wait_done_d = wait_done_q;
    left_d      = left_q;
    ready_d     = ready_q;
    if (wait_en) begin
      if (wait_cnt_q == WW'(INIT_WAIT_CYC - 1)) begin
        wait_done_d = 1'b1;
        left_d      = CW'(INIT_CBR_CNT);
      end else begin
        wait_cnt_d = wait_cnt_q + WW'(1);
      end
    end
    if (cyc_start && (left_q != '0)) begin
      left_d = left_q - CW'(1);
    end
    if (cyc_done && wait_done_q && (left_q == '0)) begin
      ready_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_cnt_q  <= '0;
      wait_done_q <= 1'b0;
      left_q      <= '0;
      ready_q     <= 1'b0;
    end else begin
      wait_cnt_q  <= wait_cnt_d;
      wait_done_q <= wait_done_d;
      left_q      <= left_d;
      ready_q     <= ready_d;
    end
  end

  assign wait_done    = wait_done_q;
  assign init_left_nz = (left_q != '0);
  assign ready        = ready_q;

  // R3: readiness never arrives while init cycles remain
  p_ready_after_burst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |-> (left_q == '0) && wait_done_q);

  // R2: no cycle may start before the wait is over
  p_no_start_in_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wait_done_q |-> !cyc_start);

endmodule

// File: rtl/rfsh_interval.sv
module rfsh_interval
  import dram_rfsh_pkg::*;
#(
  parameter int unsigned RFSH_INTERVAL = 1550,
  parameter int unsigned MAX_PENDING   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic take,
  output logic pend_nz
);

  localparam int unsigned TW = cnt_w(RFSH_INTERVAL);
  localparam int unsigned PW = cnt_w(MAX_PENDING + 1);

  logic [TW-1:0] tcnt_q, tcnt_d;
  logic [PW-1:0] pend_q, pend_d;
  logic          tick;
  logic          at_cap;

  assign tick   = run && (tcnt_q == TW'(RFSH_INTERVAL - 1));
  assign at_cap = (pend_q == PW'(MAX_PENDING));

  always_comb begin
    tcnt_d = tcnt_q;
    if (run) begin
      tcnt_d = tick ? '0 : tcnt_q + TW'(1);
    end
  end

  always_comb begin
    pend_d = pend_q;
    if (tick && !take) begin
      if (!at_cap) pend_d = pend_q + PW'(1);
    end else if (take && !tick) begin
      pend_d = pend_q - PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt_q <= '0;
      pend_q <= '0;
    end else begin
      tcnt_q <= tcnt_d;
      pend_q <= pend_d;
    end
  end

  assign pend_nz = (pend_q != '0);

  // R9: the pending count never exceeds its cap
  p_pend_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q <= PW'(MAX_PENDING));

  // R9: a cycle is only charged against existing work
  p_take_has_work_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (pend_q != '0));

  // R8: the interval counter is idle until the memory is ready
  p_timer_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(tcnt_q));

endmodule

// File: rtl/cbr_cycle_fsm.sv
module cbr_cycle_fsm
  import dram_rfsh_pkg::*;
#(
  parameter int unsigned T_CSR = 1,
  parameter int unsigned T_RAS = 6,
  parameter int unsigned T_RP  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic due,
  input  logic bus_gnt,
  output logic cyc_start,
  output logic cyc_done,
  output logic bus_req,
  output logic drv_en,
  output logic ras_n,
  output logic cas_n
);

  localparam int unsigned TMAX0 = (T_CSR > T_RAS) ? T_CSR : T_RAS;
  localparam int unsigned TMAX  = (TMAX0 > T_RP) ? TMAX0 : T_RP;
  localparam int unsigned TW    = cnt_w(TMAX);

  cbr_st_e       st_q, st_d;
  logic [TW-1:0] tm_q, tm_d;
  logic          ras_q, cas_q, req_q, drv_q;
  logic          tm_zero;

  assign tm_zero = (tm_q == '0);

  always_comb begin
    st_d      = st_q;
    tm_d      = tm_q;
    cyc_start = 1'b0;
    cyc_done  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (due) st_d = ST_REQ;
      end
      ST_REQ: begin
        if (bus_gnt) begin
          st_d      = ST_CSU;
          tm_d      = TW'(T_CSR - 1);
          cyc_start = 1'b1;
        end
      end
      ST_CSU: begin
        if (tm_zero) begin
          st_d = ST_RAS;
          tm_d = TW'(T_RAS - 1);
        end else begin
          tm_d = tm_q - TW'(1);
        end
      end
      ST_RAS: begin
        if (tm_zero) begin
          st_d = ST_PRE;
          tm_d = TW'(T_RP - 1);
        end else begin
          tm_d = tm_q - TW'(1);
        end
      end
      ST_PRE: begin
        if (tm_zero) begin
          cyc_done = 1'b1;
          if (due) begin
            st_d      = ST_CSU;
            tm_d      = TW'(T_CSR - 1);
            cyc_start = 1'b1;
          end else begin
            st_d = ST_IDLE;
          end
        end else begin
          tm_d = tm_q - TW'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      tm_q  <= '0;
      ras_q <= 1'b1;
      cas_q <= 1'b1;
      req_q <= 1'b0;
      drv_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      tm_q  <= tm_d;
      ras_q <= (st_d != ST_RAS);
      cas_q <= !((st_d == ST_CSU) || (st_d == ST_RAS));
      req_q <= (st_d != ST_IDLE);
      drv_q <= (st_d == ST_CSU) || (st_d == ST_RAS) || (st_d == ST_PRE);
    end
  end

  assign ras_n   = ras_q;
  assign cas_n   = cas_q;
  assign bus_req = req_q;
  assign drv_en  = drv_q;

  // R4: CAS is already low in the cycle before RAS falls
  p_cas_leads_ras_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

  // R4: CAS covers the whole RAS-low window
  p_cas_covers_ras_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> !cas_n);

  // R7: strobes are quiet unless the pins are owned
  p_quiet_unowned_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en |-> (ras_n && cas_n));

  // R7: an outstanding request is not withdrawn before it is granted
  p_req_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !drv_en) |=> bus_req);

  // R11: ownership implies the request is still asserted
  p_own_needs_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en |-> bus_req);

endmodule

// File: rtl/dram_rfsh_seq.sv
module dram_rfsh_seq
  import dram_rfsh_pkg::*;
#(
  parameter int unsigned INIT_WAIT_CYC = 20000,
  parameter int unsigned INIT_CBR_CNT  = 8,
  parameter int unsigned RFSH_INTERVAL = 1550,
  parameter int unsigned MAX_PENDING   = 4,
  parameter int unsigned T_CSR         = 1,
  parameter int unsigned T_RAS         = 6,
  parameter int unsigned T_RP          = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_gnt,
  input  logic host_req,
  output logic bus_req,
  output logic drv_en,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic mem_ready,
  output logic host_ok
);

  logic [1:0] rst_sync_q;
  logic       rst_ni;
  logic       wait_done;
  logic       init_left_nz;
  logic       pend_nz;
  logic       due;
  logic       take;
  logic       cyc_start;
  logic       cyc_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  assign due  = wait_done && (init_left_nz || pend_nz);
  assign take = cyc_start && !init_left_nz;

  rfsh_init_ctl #(
    .INIT_WAIT_CYC(INIT_WAIT_CYC),
    .INIT_CBR_CNT (INIT_CBR_CNT)
  ) u_init (
    .clk         (clk),
    .rst_n       (rst_ni),
    .cyc_start   (cyc_start),
    .cyc_done    (cyc_done),
    .wait_done   (wait_done),
    .init_left_nz(init_left_nz),
    .ready       (mem_ready)
  );

  rfsh_interval #(
    .RFSH_INTERVAL(RFSH_INTERVAL),
    .MAX_PENDING  (MAX_PENDING)
  ) u_ivl (
    .clk    (clk),
    .rst_n  (rst_ni),
    .run    (mem_ready),
    .take   (take),
    .pend_nz(pend_nz)
  );

  cbr_cycle_fsm #(
    .T_CSR(T_CSR),
    .T_RAS(T_RAS),
    .T_RP (T_RP)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_ni),
    .due      (due),
    .bus_gnt  (bus_gnt),
    .cyc_start(cyc_start),
    .cyc_done (cyc_done),
    .bus_req  (bus_req),
    .drv_en   (drv_en),
    .ras_n    (ras_n),
    .cas_n    (cas_n)
  );

  assign we_n    = 1'b1;
  assign host_ok = host_req && mem_ready;

  // R2: nothing is requested during the settling wait
  p_silent_wait_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    !wait_done |-> !bus_req);

  // R3: readiness is sticky
  p_ready_sticky_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_ready |=> mem_ready);

  // R9: steady-state cycles only start when work was counted
  p_start_has_due_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    cyc_start |-> due);

endmodule

// File: tb/dram_rfsh_seq_test.sv
`timescale 1ns/1ps
module dram_rfsh_seq_test;

  localparam int WAITC = 40;
  localparam int NCBR  = 8;
  localparam int IVL   = 30;
  localparam int MAXP  = 3;
  localparam int TCSR  = 2;
  localparam int TRAS  = 3;
  localparam int TRP   = 2;
  localparam int CYCL  = TCSR + TRAS + TRP;

  logic clk, rst_n, bus_gnt, host_req;
  logic bus_req, drv_en, ras_n, cas_n, we_n, mem_ready, host_ok;

  int compared, mismatched;
  bit finished;

  dram_rfsh_seq #(
    .INIT_WAIT_CYC(WAITC), .INIT_CBR_CNT(NCBR), .RFSH_INTERVAL(IVL),
    .MAX_PENDING(MAXP), .T_CSR(TCSR), .T_RAS(TRAS), .T_RP(TRP)
  ) uut (
    .clk(clk), .rst_n(rst_n), .bus_gnt(bus_gnt), .host_req(host_req),
    .bus_req(bus_req), .drv_en(drv_en), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .mem_ready(mem_ready), .host_ok(host_ok)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_sync, m_wc, m_left, m_pend, m_tc, m_ph, m_cnt, e_since;
  bit m_done, m_ready;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync = 0; m_wc = 0; m_left = 0; m_pend = 0; m_tc = 0;
      m_ph = 0; m_cnt = 0; m_done = 0; m_ready = 0; e_since = 0;
    end else begin
      e_since++;
      if (m_sync < 2) m_sync++;
      else begin
        bit due, fin, st, tick, take;
        int n_ph, n_cnt, n_left, n_pend, n_wc, n_tc;
        bit n_done, n_ready;
        due  = m_done && (m_left > 0 || m_pend > 0);
        fin  = (m_ph == 4) && (m_cnt == 0);
        st   = ((m_ph == 1) && bus_gnt) || (fin && due);
        take = st && (m_left == 0);
        tick = m_ready && (m_tc == IVL - 1);
        n_done = m_done; n_left = m_left; n_wc = m_wc;
        if (!m_done) begin
          if (m_wc == WAITC - 1) begin n_done = 1; n_left = NCBR; end
          else n_wc = m_wc + 1;
        end
        if (st && m_left > 0) n_left = m_left - 1;
        n_pend = m_pend;
        if (tick && !take) n_pend = (m_pend < MAXP) ? m_pend + 1 : m_pend;
        else if (take && !tick) n_pend = m_pend - 1;
        n_tc = m_tc;
        if (m_ready) n_tc = (m_tc == IVL - 1) ? 0 : m_tc + 1;
        n_ready = m_ready || (fin && m_done && m_left == 0);
        n_ph = m_ph; n_cnt = m_cnt;
        case (m_ph)
          0: if (due) n_ph = 1;
          1: if (bus_gnt) begin n_ph = 2; n_cnt = TCSR - 1; end
          2: if (m_cnt == 0) begin n_ph = 3; n_cnt = TRAS - 1; end else n_cnt = m_cnt - 1;
          3: if (m_cnt == 0) begin n_ph = 4; n_cnt = TRP - 1; end else n_cnt = m_cnt - 1;
          default: if (m_cnt == 0) begin
                     if (due) begin n_ph = 2; n_cnt = TCSR - 1; end else n_ph = 0;
                   end else n_cnt = m_cnt - 1;
        endcase
        m_ph = n_ph; m_cnt = n_cnt; m_left = n_left; m_pend = n_pend;
        m_wc = n_wc; m_tc = n_tc; m_done = n_done; m_ready = n_ready;
      end
    end
  end

  // ---------------- grant driver ----------------
  int req_age, gnt_lat;
  bit gnt_allow, spur;
  always @(negedge clk) begin
    if (bus_req) req_age++; else req_age = 0;
    bus_gnt = (bus_req && gnt_allow && req_age > gnt_lat) || (!bus_req && spur);
  end

  // ---------------- per-cycle comparison and monitors ----------------
  int cyc, csu_run, ras_run, init_falls, n_falls, last_fall;
  bit prev_ras, prev_rdy, seen_req, meas_ivl;

  always @(negedge clk) begin
    #1;
    if (rst_n && !finished) begin
      cyc++;
      chk("R4/R5 ras_n", ras_n, (m_ph == 3) ? 0 : 1);
      chk("R4 cas_n", cas_n, (m_ph == 2 || m_ph == 3) ? 0 : 1);
      chk("R6 we_n", we_n, 1);
      chk("R7 bus_req", bus_req, (m_ph != 0) ? 1 : 0);
      chk("R11 drv_en", drv_en, (m_ph >= 2) ? 1 : 0);
      chk("R3 mem_ready", mem_ready, m_ready);
      chk("R10 host_ok", host_ok, (host_req && m_ready) ? 1 : 0);
      if (!bus_req) chk("R7 strobes idle without request", ras_n & cas_n, 1);
      if (!seen_req && bus_req) begin
        seen_req = 1;
        chk("R2 first request edge", e_since, WAITC + 3);
      end
      if (cas_n == 0 && ras_n == 1) csu_run++;
      if (ras_n == 0) ras_run++;
      if (prev_ras && !ras_n) begin
        chk("R4 cas lead cycles", csu_run, TCSR);
        csu_run = 0;
        n_falls++;
        if (!mem_ready) init_falls++;
        if (meas_ivl) begin
          if (last_fall >= 0) chk("R8 refresh spacing", cyc - last_fall, IVL);
          last_fall = cyc;
        end
      end
      if (!prev_ras && ras_n) begin
        chk("R5 ras low width", ras_run, TRAS);
        ras_run = 0;
      end
      if (!prev_rdy && mem_ready) chk("R3 init cycles before ready", init_falls, NCBR);
      prev_ras = ras_n;
      prev_rdy = mem_ready;
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    rst_n = 1'b0; host_req = 1'b0; gnt_allow = 1; spur = 0; gnt_lat = 2;
    bus_gnt = 1'b0; prev_ras = 1; prev_rdy = 0; last_fall = -1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset ras_n", ras_n, 1);
    chk("R1 reset cas_n", cas_n, 1);
    chk("R1 reset we_n", we_n, 1);
    chk("R1 reset bus_req", bus_req, 0);
    chk("R1 reset drv_en", drv_en, 0);
    chk("R1 reset mem_ready", mem_ready, 0);
    chk("R1 reset host_ok", host_ok, 0);
    @(negedge clk);
    rst_n = 1'b1;
    host_req = 1'b1;
    for (int i = 0; i < 400 && !mem_ready; i++) @(negedge clk);
    chk("R3 ready reached", mem_ready, 1);
    #1;
    chk("R10 host accepted once ready", host_ok, 1);
    gnt_lat = 1;
    repeat (IVL + 10) @(negedge clk);
    meas_ivl = 1; last_fall = -1;
    repeat (5 * IVL) @(negedge clk);
    meas_ivl = 0;
    host_req = 1'b0;
    spur = 1;
    repeat (2 * IVL) @(negedge clk);
    spur = 0;
    for (int i = 0; i < 3 * IVL && bus_req; i++) @(negedge clk);
    gnt_allow = 0;
    repeat (150) @(negedge clk);
    chk("R7 request held without grant", bus_req, 1);
    begin
      int f0;
      f0 = n_falls;
      gnt_allow = 1;
      repeat (MAXP * CYCL + 1) @(negedge clk);
      chk("R9 back-to-back capped burst", n_falls - f0, MAXP);
    end
    repeat (3 * IVL) @(negedge clk);
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      compared++; mismatched++;
      $display("FAIL watchdog: run did not complete actual=0 expected=1");
      summary();
      $finish;
    end
  end

endmodule